// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs a source address, a destination address and a 32-bit control word through a small register write port. Setting the enable bit arms the channel. The transfer then starts at once, or it waits for an external start event, depending on the timing field. The engine moves a programmed number of 16-bit or 32-bit chunks. Each chunk is one read beat followed by one write beat on a simple request/acknowledge memory master. After every chunk, the source and destination addresses are adjusted according to their own mode fields.

When a block finishes, the channel can raise a one-cycle interrupt pulse. The enable bit then clears itself, unless repeat is set with an event-driven timing mode. In that case the channel re-arms for the next start event. The count reloads and the source keeps advancing. The destination reloads only in its increment-and-restore mode. Clearing the enable bit during a block stops the channel once the chunk in progress has been written.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `ch_en`, `rd_req`, `wr_req`, `done_irq` and `src_mode_err` are all low.
- R2: A write with `cfg_sel`=0 loads the 28-bit source address from `cfg_wdata[27:0]`. `cfg_sel`=1 loads the 27-bit destination address from `cfg_wdata[26:0]`. `cfg_sel`=2 loads the control word, whose fields are: count [15:0], destination mode [22:21], source mode [24:23], repeat [25], chunk size [26], timing [29:28], interrupt enable [30] and enable [31]. A 0-to-1 write of enable copies the programmed addresses into the working addresses.
- R3: With timing 00, if the enabling write is presented in cycle n, `rd_req` is low in cycle n+1 and first high in cycle n+2.
- R4: Chunk size 0 moves halfwords and steps the addresses by 2. Chunk size 1 moves words and steps them by 4. `xfer_word` shows the chunk size.
- R5: Address mode 00 increments after each chunk, 01 decrements and 10 holds the address fixed. This applies to both source and destination.
- R6: Destination mode 11 increments after each chunk and restores the programmed destination when the block completes.
- R7: Source mode 11 is illegal. While it is programmed, `src_mode_err` is high and the source address is held fixed.
- R8: The count is in chunks. A count of 0 moves 65536 chunks.
- R9: With timing 01, 10 or 11, no read is requested until a `start_evt` pulse is seen while the channel is armed.
- R10: When the last chunk of a block is written, `done_irq` pulses for exactly one cycle if interrupt enable is set. The enable bit clears unless repeat is set with a non-zero timing.
- R11: On a repeat re-arm, the enable bit stays set, the count reloads, the source continues from its current address, and the destination reloads only in mode 11.
- R12: Writing the control word with enable 0 during a block lets the chunk active in the cycle after that write finish. No further chunk starts and no interrupt is raised.
- R13: `rd_req` is held with a stable address until `rd_ack`. The read data of a chunk is written unchanged to `wr_data`. `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wdata | input | 32 | Register write data |
| start_evt | input | 1 | Start event pulse for the event-driven timing modes |
| ch_en | output | 1 | Current value of the enable bit |
| src_mode_err | output | 1 | Illegal source mode programmed |
| done_irq | output | 1 | One-cycle block completion pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 28 | Read address |
| rd_ack | input | 1 | Read acknowledge, with `rd_data` valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 27 | Write address |
| wr_data | output | 32 | Write data |
| xfer_word | output | 1 | 1 for word chunks, 0 for halfword chunks |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The simulated memory returns read data derived from the read address. Each logged write therefore shows both the source and the destination address of its chunk, and a reference list built in the bench is compared with the log.

The copy is tried with several setups:
- Word increment/increment shows the basic chunk sequence.
- Halfword decrement into a fixed destination separates step size from direction.
- Increment-and-restore under repeated start events exposes the reload rules, because the second block must reuse the destination but not the source.
- The illegal source mode, the mid-block abort and the zero count each isolate one corner of the completion logic.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int SRC_W  = 28,
  parameter int DST_W  = 27,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              start_evt,
  output logic              ch_en,
  output logic              src_mode_err,
  output logic              done_irq,
  output logic              rd_req,
  output logic [SRC_W-1:0]  rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [DST_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              xfer_word,
  input  logic              wr_ack
);
  localparam int CW = CNT_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_ARM, S_RD, S_WR} st_t;
  st_t st;

  logic              en_q, ie_q, rep_q, cs_q;
  logic [1:0]        tm_q, sa_q, da_q;
  logic [CNT_W-1:0]  n_q;
  logic [SRC_W-1:0]  src_prog, src_cur, src_nxt, s_step;
  logic [DST_W-1:0]  dst_prog, dst_cur, dst_nxt, d_step;
  logic [CW-1:0]     left, reload_cnt, start_cnt;
  logic [DATA_W-1:0] buf_q;
  logic              ctl_wr, en_rise;
  logic              unused_bits;

  assign unused_bits = ^{cfg_wdata[27], cfg_wdata[20:16]};

  assign ctl_wr     = cfg_we && cfg_sel == 2'd2;
  assign en_rise    = ctl_wr && cfg_wdata[31] && !en_q;
  assign reload_cnt = (n_q == '0) ? (CW'(1) << CNT_W) : CW'(n_q);
  assign start_cnt  = (cfg_wdata[CNT_W-1:0] == '0) ? (CW'(1) << CNT_W) : CW'(cfg_wdata[CNT_W-1:0]);

  assign s_step = cs_q ? SRC_W'(4) : SRC_W'(2);
  assign d_step = cs_q ? DST_W'(4) : DST_W'(2);

  always_comb begin
    case (sa_q)
      2'b00:   src_nxt = src_cur + s_step;
      2'b01:   src_nxt = src_cur - s_step;
      default: src_nxt = src_cur;
    endcase
    case (da_q)
      2'b01:   dst_nxt = dst_cur - d_step;
      2'b10:   dst_nxt = dst_cur;
      default: dst_nxt = dst_cur + d_step;
    endcase
  end

  assign ch_en        = en_q;
  assign src_mode_err = (sa_q == 2'b11);
  assign rd_req       = (st == S_RD);
  assign wr_req       = (st == S_WR);
  assign rd_addr      = src_cur;
  assign wr_addr      = dst_cur;
  assign wr_data      = buf_q;
  assign xfer_word    = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {en_q, ie_q, rep_q, cs_q} <= '0;
      {tm_q, sa_q, da_q} <= '0;
      n_q <= '0;
      src_prog <= '0; src_cur <= '0;
      dst_prog <= '0; dst_cur <= '0;
      left <= '0; buf_q <= '0; done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (st)
        S_DLY: st <= en_q ? S_RD : S_IDLE;
        S_ARM: if (!en_q) st <= S_IDLE; else if (start_evt) st <= S_RD;
        S_RD:  if (rd_ack) begin buf_q <= rd_data; st <= S_WR; end
        S_WR:  if (wr_ack) begin
          src_cur <= src_nxt;
          dst_cur <= dst_nxt;
          left    <= left - CW'(1);
          if (!en_q) st <= S_IDLE;
          else if (left == CW'(1)) begin
            done_irq <= ie_q;
            left     <= reload_cnt;
            if (da_q == 2'b11) dst_cur <= dst_prog;
            if (rep_q && tm_q != 2'b00) st <= S_ARM;
            else begin st <= S_IDLE; en_q <= 1'b0; end
          end else st <= S_RD;
        end
        default: ;
      endcase
      if (cfg_we && cfg_sel == 2'd0) src_prog <= cfg_wdata[SRC_W-1:0];
      if (cfg_we && cfg_sel == 2'd1) dst_prog <= cfg_wdata[DST_W-1:0];
      if (ctl_wr) begin
        en_q <= cfg_wdata[31]; ie_q <= cfg_wdata[30]; tm_q <= cfg_wdata[29:28];
        cs_q <= cfg_wdata[26]; rep_q <= cfg_wdata[25]; sa_q <= cfg_wdata[24:23];
        da_q <= cfg_wdata[22:21]; n_q <= cfg_wdata[CNT_W-1:0];
      end
      if (en_rise) begin
        src_cur <= src_prog;
        dst_cur <= dst_prog;
        left    <= start_cnt;
        st      <= (cfg_wdata[29:28] == 2'b00) ? S_DLY : S_ARM;
      end
    end
  end

  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !cfg_we |=> rd_req && $stable(rd_addr));
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  a_r7_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && src_mode_err && !cfg_we |=> $stable(src_cur));
  a_r5_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && da_q == 2'b10 && !cfg_we |=> $stable(dst_cur));
endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, start_evt = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        ch_en, src_mode_err, done_irq, rd_req, wr_req, xfer_word;
  logic [27:0] rd_addr;
  logic [26:0] wr_addr;
  logic [31:0] rd_data, wr_data;
  logic        rd_ack = 0, wr_ack = 0;

  int tests = 0, fails = 0, irq_cnt = 0;
  logic [26:0] wa_q[$];
  logic [31:0] wd_q[$];
  bit          ws_q[$];

  always #4 clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start_evt(start_evt), .ch_en(ch_en), .src_mode_err(src_mode_err), .done_irq(done_irq),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .xfer_word(xfer_word),
    .wr_ack(wr_ack));

  assign rd_data = {4'hA, rd_addr};

  always @(negedge clk) begin
    rd_ack <= rd_req && !rd_ack;
    if (wr_req && !wr_ack) begin
      wr_ack <= 1'b1;
      wa_q.push_back(wr_addr); wd_q.push_back(wr_data); ws_q.push_back(xfer_word);
    end else wr_ack <= 1'b0;
    if (done_irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit en, bit ie, logic [1:0] tm, bit cs, bit rep,
                                      logic [1:0] sa, logic [1:0] da, logic [15:0] n);
    return {en, ie, tm, 1'b0, cs, rep, sa, da, 5'd0, n};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      if (!ch_en && !rd_req && !wr_req) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic exp_wr(input string tag, input int idx, input logic [26:0] a,
                        input logic [27:0] s, input bit word);
    if (idx >= wa_q.size()) begin chk(0, tag, wa_q.size(), idx + 1); return; end
    chk(wa_q[idx] == a, tag, wa_q[idx], a);
    chk(wd_q[idx] == {4'hA, s}, tag, wd_q[idx], {4'hA, s});
    chk(ws_q[idx] == word, tag, ws_q[idx], word);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ch_en && !rd_req && !wr_req && !done_irq && !src_mode_err, "R1 reset outputs",
        {ch_en, rd_req, wr_req, done_irq, src_mode_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 R10: word inc/inc, immediate, irq
    wr(0, 32'h40); wr(1, 32'h80);
    wr(2, ctl(1, 1, 0, 1, 0, 0, 0, 3));
    @(negedge clk); chk(!rd_req, "R3 no req in n+1", rd_req, 0);
    @(negedge clk); chk(rd_req, "R3 req in n+2", rd_req, 1);
    chk(rd_addr == 28'h40, "R2 src loaded", rd_addr, 28'h40);
    wait_idle();
    chk(wa_q.size() == 3, "R4 word count", wa_q.size(), 3);
    for (int i = 0; i < 3; i++) exp_wr("R5 R13 word inc", i, 27'h80 + 27'(4*i), 28'h40 + 28'(4*i), 1);
    chk(irq_cnt == 1, "R10 one irq", irq_cnt, 1);
    chk(!ch_en, "R10 enable cleared", ch_en, 0);

    // R4 R5: halfword, src decrement, dst fixed, no irq
    wa_q.delete(); wd_q.delete(); ws_q.delete(); irq_cnt = 0;
    wr(0, 32'h1000); wr(1, 32'h300);
    wr(2, ctl(1, 0, 0, 0, 0, 1, 2, 4));
    wait_idle();
    chk(wa_q.size() == 4, "R4 half count", wa_q.size(), 4);
    for (int i = 0; i < 4; i++) exp_wr("R4 R5 half dec fixed", i, 27'h300, 28'h1000 - 28'(2*i), 0);
    chk(irq_cnt == 0, "R10 no irq when disabled", irq_cnt, 0);

    // R9 R11 R6: event timing, repeat, dst mode 11
    wa_q.delete(); wd_q.delete(); ws_q.delete(); irq_cnt = 0;
    wr(0, 32'h100); wr(1, 32'h200);
    wr(2, ctl(1, 1, 1, 0, 1, 0, 3, 3));
    repeat (5) @(negedge clk);
    chk(wa_q.size() == 0 && !rd_req, "R9 waits for event", wa_q.size(), 0);
    start_evt = 1; @(posedge clk); #1; start_evt = 0;
    repeat (20) @(negedge clk);
    chk(ch_en, "R11 stays armed", ch_en, 1);
    chk(irq_cnt == 1, "R10 irq first block", irq_cnt, 1);
    start_evt = 1; @(posedge clk); #1; start_evt = 0;
    repeat (20) @(negedge clk);
    chk(wa_q.size() == 6, "R11 two blocks", wa_q.size(), 6);
    for (int i = 0; i < 6; i++)
      exp_wr("R6 R11 reload", i, 27'h200 + 27'(2*(i%3)), 28'h100 + 28'(2*i), 0);
    chk(irq_cnt == 2, "R10 irq each block", irq_cnt, 2);
    wr(2, ctl(0, 1, 1, 0, 1, 0, 3, 3));
    wait_idle();
    chk(!ch_en && wa_q.size() == 6, "R12 disarm idle", wa_q.size(), 6);

    // R11: repeat with immediate timing does not re-arm
    wa_q.delete(); wd_q.delete(); ws_q.delete();
    wr(2, ctl(1, 0, 0, 1, 1, 0, 0, 1));
    wait_idle();
    chk(!ch_en && wa_q.size() == 1, "R11 immediate no rearm", wa_q.size(), 1);

    // R7: illegal source mode
    wa_q.delete(); wd_q.delete(); ws_q.delete();
    wr(0, 32'h500); wr(1, 32'h600);
    wr(2, ctl(1, 0, 0, 1, 0, 3, 0, 2));
    chk(src_mode_err, "R7 error flag", src_mode_err, 1);
    wait_idle();
    for (int i = 0; i < 2; i++) exp_wr("R7 src fixed", i, 27'h600 + 27'(4*i), 28'h500, 1);

    // R12: abort mid block
    wa_q.delete(); wd_q.delete(); ws_q.delete(); irq_cnt = 0;
    wr(0, 32'h40); wr(1, 32'h80);
    wr(2, ctl(1, 1, 0, 1, 0, 0, 0, 10));
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (wa_q.size() == 3) break;
    end
    wr(2, ctl(0, 1, 0, 1, 0, 0, 0, 10));
    repeat (12) @(negedge clk);
    chk(wa_q.size() == 4, "R12 abort count", wa_q.size(), 4);
    chk(irq_cnt == 0, "R12 no irq", irq_cnt, 0);
    chk(!ch_en && !rd_req, "R12 idle", ch_en, 0);

    // R8: zero count is 65536
    wa_q.delete(); wd_q.delete(); ws_q.delete();
    wr(2, ctl(1, 0, 0, 1, 0, 2, 2, 0));
    wait_idle();
    chk(wa_q.size() == 65536, "R8 zero count", wa_q.size(), 65536);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule